// File: doc/BRIEF.md
# Configuration Line Loader

This block performs the initialization step of a decoder core. After a start pulse it reads a 26-bit-wide configuration memory, one line per clock, through a synchronous read port with one cycle of latency. Each returned line is split into named parameter fields. These cover the core identity and tail flag, two address seeds, the iteration and trellis settings, eight step values, the tail-bit base address, the extrinsic scaling factor and the standard selector. They also cover the block length, the core count, the step index, and the window sizes and counts. When the last line has been taken, all parameter outputs change together and a ready flag rises.

The sequence has a fixed budget. One setup cycle comes first, then one read cycle per line, then one completion cycle. After completion the block leaves the memory port idle, so the next configuration can be written while the decoder runs. A size input sets how many lines are read, which allows shorter or longer layouts. Window sizes and window counts are checked against their limits. A configuration that breaks a limit raises an error flag and is not applied.

Top module: `cfg_line_loader`

## Requirements
- R1: While reset is high, and after it, until the first start: busy, ready, cfg_err and cfg_rd_en are low and every parameter output is zero.
- R2: A start taken while idle is followed by one setup cycle with no read. Reads then come on consecutive cycles with cfg_rd_addr = 0, 1, …, N-1, where N is cfg_len, and any cfg_len above 16 is treated as 16.
- R3: busy is high for exactly N+2 cycles, starting the cycle after start is sampled. ready or cfg_err is valid in the first cycle after busy falls. The read data for an address is taken the cycle after that address is issued.
- R4: Line 0 gives core_id in bits [3:0] and tail_en in bit 25. Line 1 gives seed_a in [25:13] and seed_b in [12:0]. Line 2 gives iter_init in [23:18], iter_max in [17:12], trellis_states in [11:6] and step_count in [5:0].
- R5: Line 3+k (k = 0..3) gives step value 2k in bits [25:13] and step value 2k+1 in [12:0]. Step value j appears on step_vals[13j+12:13j].
- R6: Line 7 gives tail_base in [25:16], ext_scale in [15:8] and std_mode in [1:0]. Line 8 gives prev_step in [25:13] and block_len in [12:0].
- R7: Line 9 gives core_count in [23:20], step_index in [19:14], win_len in [13:7] and last_win_len in [6:0]. Line 10 gives win_cnt in [11:8], tail_win_id in [7:4] and tail_win_cnt in [3:0].
- R8: Fields on lines that were not read keep their previously applied values. Data read from addresses 11 and above has no effect on any output.
- R9: During a load the parameter outputs hold their previous values and ready is low. All fields update together on completion.
- R10: If the merged result has win_len or last_win_len above 64, or win_cnt or tail_win_cnt above 12, then cfg_err rises, ready stays low and the outputs keep their previous values. A value of exactly 64 or 12 is accepted.
- R11: A start pulse while busy is ignored: the load runs its normal length and no second load follows.
- R12: After completion no read is issued until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (taken only while idle) |
| cfg_len | input | 5 | Number of lines to read, clamped to 16 |
| cfg_rd_en | output | 1 | Memory read enable |
| cfg_rd_addr | output | 4 | Memory read address |
| cfg_rd_data | input | 26 | Memory read data, one cycle after the address |
| busy | output | 1 | Load in progress |
| ready | output | 1 | Last load applied successfully |
| cfg_err | output | 1 | Last load rejected by a range check |
| core_id | output | 4 | Core identifier |
| tail_en | output | 1 | Core handles the tail bits |
| seed_a | output | 13 | Address-generation seed A |
| seed_b | output | 13 | Address-generation seed B |
| iter_init | output | 6 | Initial iteration |
| iter_max | output | 6 | Maximum iteration |
| trellis_states | output | 6 | Trellis state field |
| step_count | output | 6 | Number of steps |
| step_vals | output | 104 | Eight 13-bit step values |
| tail_base | output | 10 | Tail-bit memory address |
| ext_scale | output | 8 | Extrinsic scaling factor |
| std_mode | output | 2 | Standard/mode selector |
| prev_step | output | 13 | Previous step value |
| block_len | output | 13 | Block length in bits |
| core_count | output | 4 | Number of cores |
| step_index | output | 6 | Step index |
| win_len | output | 7 | Window size in symbols |
| last_win_len | output | 7 | Last-window size |
| win_cnt | output | 4 | Normal window count |
| tail_win_id | output | 4 | Tail window identifier |
| tail_win_cnt | output | 4 | Tail window count |

## Verification
A sequencer that takes the wrong state shows up at once on the read port: a missing setup cycle, a skipped or repeated address, or a load that runs one cycle too long or too short. Each of these is visible within one clock. A capture register aligned to the wrong cycle, or a slice off by one position, puts a neighbouring line's bits into a field, and this appears at the completion edge. A shadow register that is not reloaded from the applied values appears only on a later short load, as a stale field on an unread line. For that reason the bench sweeps every length from 0 to 20, each with a fresh data pattern.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int LINE_W  = 26;
  localparam int CORE_W  = 4;
  localparam int SEED_W  = 13;
  localparam int ITER_W  = 6;
  localparam int NSTEP   = 8;
  localparam int STEP_W  = 13;
  localparam int TADDR_W = 10;
  localparam int SCALE_W = 8;
  localparam int MODE_W  = 2;
  localparam int BLK_W   = 13;
  localparam int NCORE_W = 4;
  localparam int SIDX_W  = 6;
  localparam int WSZ_W   = 7;
  localparam int WCNT_W  = 4;
  localparam int WID_W   = 4;
  localparam int LAST_LINE = 10;

  typedef struct packed {
    logic [CORE_W-1:0]              core_id;
    logic                           tail;
    logic [SEED_W-1:0]              seed_a;
    logic [SEED_W-1:0]              seed_b;
    logic [ITER_W-1:0]              iter_init;
    logic [ITER_W-1:0]              iter_max;
    logic [ITER_W-1:0]              trellis_states;
    logic [ITER_W-1:0]              step_count;
    logic [NSTEP-1:0][STEP_W-1:0]   step;
    logic [TADDR_W-1:0]             tail_base;
    logic [SCALE_W-1:0]             ext_scale;
    logic [MODE_W-1:0]              std_mode;
    logic [STEP_W-1:0]              prev_step;
    logic [BLK_W-1:0]               block_len;
    logic [NCORE_W-1:0]             core_count;
    logic [SIDX_W-1:0]              step_index;
    logic [WSZ_W-1:0]               win_len;
    logic [WSZ_W-1:0]               last_win_len;
    logic [WCNT_W-1:0]              win_cnt;
    logic [WID_W-1:0]               tail_win_id;
    logic [WCNT_W-1:0]              tail_win_cnt;
  } cfg_params_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_READ   = 2'd2,
    SQ_FINISH = 2'd3
  } seq_state_t;

  // Place one configuration line into the parameter set; lines past the
  // last defined one leave it unchanged.
  function automatic cfg_params_t cfg_merge(input cfg_params_t cur,
                                            input int line,
                                            input logic [LINE_W-1:0] d);
    cfg_params_t p;
    int k;
    p = cur;
    k = 0;
    case (line)
      0: begin
        p.core_id = d[CORE_W-1:0];
        p.tail    = d[LINE_W-1];
      end
      1: begin
        p.seed_a = d[25:13];
        p.seed_b = d[12:0];
      end
      2: begin
        p.iter_init      = d[23:18];
        p.iter_max       = d[17:12];
        p.trellis_states = d[11:6];
        p.step_count     = d[5:0];
      end
      3, 4, 5, 6: begin
        k = 2 * (line - 3);
        p.step[k]     = d[25:13];
        p.step[k + 1] = d[12:0];
      end
      7: begin
        p.tail_base = d[25:16];
        p.ext_scale = d[15:8];
        p.std_mode  = d[1:0];
      end
      8: begin
        p.prev_step = d[25:13];
        p.block_len = d[12:0];
      end
      9: begin
        p.core_count   = d[23:20];
        p.step_index   = d[19:14];
        p.win_len      = d[13:7];
        p.last_win_len = d[6:0];
      end
      LAST_LINE: begin
        p.win_cnt      = d[11:8];
        p.tail_win_id  = d[7:4];
        p.tail_win_cnt = d[3:0];
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W:0]   cfg_len,
  output logic              accept,
  output logic              busy,
  output logic              commit,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_vld,
  output logic [ADDR_W-1:0] cap_addr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W + 1)'(DEPTH);

  seq_state_t        state_q;
  logic [ADDR_W:0]   len_q;
  logic [ADDR_W:0]   len_clamped;
  logic              last_addr;

  assign len_clamped = (cfg_len > DEPTH_V) ? DEPTH_V : cfg_len;
  assign last_addr   = ({1'b0, rd_addr} == (len_q - 1'b1));

  assign accept = (state_q == SQ_IDLE) && start;
  assign busy   = (state_q != SQ_IDLE);
  assign commit = (state_q == SQ_FINISH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      len_q    <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      cap_vld  <= 1'b0;
      cap_addr <= '0;
    end else begin
      cap_vld  <= rd_en;
      cap_addr <= rd_addr;
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            len_q   <= len_clamped;
            state_q <= SQ_SETUP;
          end
        end
        SQ_SETUP: begin
          rd_addr <= '0;
          if (len_q == '0) begin
            state_q <= SQ_FINISH;
          end else begin
            rd_en   <= 1'b1;
            state_q <= SQ_READ;
          end
        end
        SQ_READ: begin
          if (last_addr) begin
            rd_en   <= 1'b0;
            state_q <= SQ_FINISH;
          end else begin
            rd_addr <= rd_addr + 1'b1;
          end
        end
        default: begin
          state_q <= SQ_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/cfgld_unpack.sv
module cfgld_unpack
  import cfgld_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  cfg_params_t       applied,
  input  logic              cap_vld,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [LINE_W-1:0] rd_data,
  output cfg_params_t       merged
);

  cfg_params_t shadow_q;

  assign merged = cap_vld ? cfg_merge(shadow_q, int'(cap_addr), rd_data)
                          : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (accept) begin
      shadow_q <= applied;
    end else if (cap_vld) begin
      shadow_q <= merged;
    end
  end

endmodule

// File: rtl/cfgld_range.sv
module cfgld_range
  import cfgld_pkg::*;
#(
  parameter int MAX_WIN  = 64,
  parameter int MAX_WCNT = 12
) (
  input  cfg_params_t p,
  output logic        bad
);

  logic win_bad;
  logic cnt_bad;

  assign win_bad = (int'(p.win_len) > MAX_WIN) || (int'(p.last_win_len) > MAX_WIN);
  assign cnt_bad = (int'(p.win_cnt) > MAX_WCNT) || (int'(p.tail_win_cnt) > MAX_WCNT);
  assign bad     = win_bad || cnt_bad;

endmodule

// File: rtl/cfg_line_loader.sv
module cfg_line_loader
  import cfgld_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int MAX_WIN  = 64,
  parameter int MAX_WCNT = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W:0]          cfg_len,
  output logic                     cfg_rd_en,
  output logic [ADDR_W-1:0]        cfg_rd_addr,
  input  logic [LINE_W-1:0]        cfg_rd_data,
  output logic                     busy,
  output logic                     ready,
  output logic                     cfg_err,
  output logic [CORE_W-1:0]        core_id,
  output logic                     tail_en,
  output logic [SEED_W-1:0]        seed_a,
  output logic [SEED_W-1:0]        seed_b,
  output logic [ITER_W-1:0]        iter_init,
  output logic [ITER_W-1:0]        iter_max,
  output logic [ITER_W-1:0]        trellis_states,
  output logic [ITER_W-1:0]        step_count,
  output logic [NSTEP*STEP_W-1:0]  step_vals,
  output logic [TADDR_W-1:0]       tail_base,
  output logic [SCALE_W-1:0]       ext_scale,
  output logic [MODE_W-1:0]        std_mode,
  output logic [STEP_W-1:0]        prev_step,
  output logic [BLK_W-1:0]         block_len,
  output logic [NCORE_W-1:0]       core_count,
  output logic [SIDX_W-1:0]        step_index,
  output logic [WSZ_W-1:0]         win_len,
  output logic [WSZ_W-1:0]         last_win_len,
  output logic [WCNT_W-1:0]        win_cnt,
  output logic [WID_W-1:0]         tail_win_id,
  output logic [WCNT_W-1:0]        tail_win_cnt
);

  logic              accept;
  logic              commit;
  logic              cap_vld;
  logic [ADDR_W-1:0] cap_addr;
  logic              bad;
  cfg_params_t       applied_q;
  cfg_params_t       merged;

  cfgld_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cfg_len  (cfg_len),
    .accept   (accept),
    .busy     (busy),
    .commit   (commit),
    .rd_en    (cfg_rd_en),
    .rd_addr  (cfg_rd_addr),
    .cap_vld  (cap_vld),
    .cap_addr (cap_addr)
  );

  cfgld_unpack #(.ADDR_W(ADDR_W)) unpack_i (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .applied  (applied_q),
    .cap_vld  (cap_vld),
    .cap_addr (cap_addr),
    .rd_data  (cfg_rd_data),
    .merged   (merged)
  );

  cfgld_range #(.MAX_WIN(MAX_WIN), .MAX_WCNT(MAX_WCNT)) range_i (
    .p   (merged),
    .bad (bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      applied_q <= '0;
      ready     <= 1'b0;
      cfg_err   <= 1'b0;
    end else if (accept) begin
      ready   <= 1'b0;
      cfg_err <= 1'b0;
    end else if (commit) begin
      if (bad) begin
        cfg_err <= 1'b1;
      end else begin
        ready     <= 1'b1;
        applied_q <= merged;
      end
    end
  end

  assign core_id        = applied_q.core_id;
  assign tail_en        = applied_q.tail;
  assign seed_a         = applied_q.seed_a;
  assign seed_b         = applied_q.seed_b;
  assign iter_init      = applied_q.iter_init;
  assign iter_max       = applied_q.iter_max;
  assign trellis_states = applied_q.trellis_states;
  assign step_count     = applied_q.step_count;
  assign step_vals      = applied_q.step;
  assign tail_base      = applied_q.tail_base;
  assign ext_scale      = applied_q.ext_scale;
  assign std_mode       = applied_q.std_mode;
  assign prev_step      = applied_q.prev_step;
  assign block_len      = applied_q.block_len;
  assign core_count     = applied_q.core_count;
  assign step_index     = applied_q.step_index;
  assign win_len        = applied_q.win_len;
  assign last_win_len   = applied_q.last_win_len;
  assign win_cnt        = applied_q.win_cnt;
  assign tail_win_id    = applied_q.tail_win_id;
  assign tail_win_cnt   = applied_q.tail_win_cnt;

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W:0]   cfg_len,
  input logic              cfg_rd_en,
  input logic [ADDR_W-1:0] cfg_rd_addr,
  input logic              busy,
  input logic              ready,
  input logic              cfg_err,
  input logic [6:0]        win_len,
  input logic [12:0]       block_len,
  input logic [3:0]        core_id
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W + 1)'(DEPTH);

  logic [ADDR_W:0]   len_exp;
  logic [ADDR_W+1:0] rd_cnt;
  logic [ADDR_W+1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_exp  <= '0;
      rd_cnt   <= '0;
      busy_cnt <= '0;
    end else if (start && !busy) begin
      len_exp  <= (cfg_len > DEPTH_V) ? DEPTH_V : cfg_len;
      rd_cnt   <= '0;
      busy_cnt <= '0;
    end else begin
      if (cfg_rd_en) rd_cnt <= rd_cnt + 1'b1;
      if (busy) busy_cnt <= busy_cnt + 1'b1;
    end
  end

  p_setup_no_read_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !cfg_rd_en);

  p_first_addr_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_rd_en) |-> cfg_rd_addr == '0);

  p_addr_incr_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_en && $past(cfg_rd_en)) |-> cfg_rd_addr == $past(cfg_rd_addr) + 1'b1);

  p_read_count_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rd_cnt == {1'b0, len_exp});

  p_duration_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_cnt == {1'b0, len_exp} + 2);

  p_hold_during_load_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(win_len) && $stable(block_len) && $stable(core_id)));

  p_flags_low_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready);

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(ready && cfg_err));

  p_no_idle_read_r12: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_en |-> busy);

endmodule

bind cfg_line_loader cfgld_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .cfg_len     (cfg_len),
  .cfg_rd_en   (cfg_rd_en),
  .cfg_rd_addr (cfg_rd_addr),
  .busy        (busy),
  .ready       (ready),
  .cfg_err     (cfg_err),
  .win_len     (win_len),
  .block_len   (block_len),
  .core_id     (core_id)
);

// File: tb/cfg_line_loader_tb.sv
module cfg_line_loader_tb_top;

  localparam int NF = 28;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [4:0]    cfg_len = '0;
  logic          cfg_rd_en;
  logic [3:0]    cfg_rd_addr;
  logic [25:0]   cfg_rd_data = '0;
  logic          busy, ready, cfg_err;
  logic [3:0]    core_id;
  logic          tail_en;
  logic [12:0]   seed_a, seed_b;
  logic [5:0]    iter_init, iter_max, trellis_states, step_count;
  logic [103:0]  step_vals;
  logic [9:0]    tail_base;
  logic [7:0]    ext_scale;
  logic [1:0]    std_mode;
  logic [12:0]   prev_step, block_len;
  logic [3:0]    core_count;
  logic [5:0]    step_index;
  logic [6:0]    win_len, last_win_len;
  logic [3:0]    win_cnt, tail_win_id, tail_win_cnt;

  logic [25:0]   mem [16];
  int            cur [NF];
  int            nchk = 0;
  int            nfail = 0;
  int            ov_idx = -1;
  int            ov_val = 0;
  int            cyc = 0;

  always #2 clk = ~clk;

  cfg_line_loader dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len),
    .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .busy(busy), .ready(ready), .cfg_err(cfg_err),
    .core_id(core_id), .tail_en(tail_en), .seed_a(seed_a), .seed_b(seed_b),
    .iter_init(iter_init), .iter_max(iter_max), .trellis_states(trellis_states),
    .step_count(step_count), .step_vals(step_vals), .tail_base(tail_base),
    .ext_scale(ext_scale), .std_mode(std_mode), .prev_step(prev_step),
    .block_len(block_len), .core_count(core_count), .step_index(step_index),
    .win_len(win_len), .last_win_len(last_win_len), .win_cnt(win_cnt),
    .tail_win_id(tail_win_id), .tail_win_cnt(tail_win_cnt)
  );

  // Synchronous memory model, one cycle of read latency
  always @(posedge clk) if (cfg_rd_en) cfg_rd_data <= mem[cfg_rd_addr];

  // Field layout taken from requirements R4..R7
  function automatic int fline(int i);
    if (i <= 1) return 0;
    if (i <= 3) return 1;
    if (i <= 7) return 2;
    if (i <= 15) return 3 + (i - 8) / 2;
    if (i <= 18) return 7;
    if (i <= 20) return 8;
    if (i <= 24) return 9;
    return 10;
  endfunction

  function automatic int flsb(int i);
    case (i)
      0: return 0;   1: return 25;  2: return 13;  3: return 0;
      4: return 18;  5: return 12;  6: return 6;   7: return 0;
      16: return 16; 17: return 8;  18: return 0;  19: return 13;
      20: return 0;  21: return 20; 22: return 14; 23: return 7;
      24: return 0;  25: return 8;  26: return 4;  27: return 0;
      default: return ((i - 8) % 2 == 0) ? 13 : 0;
    endcase
  endfunction

  function automatic int fwid(int i);
    case (i)
      0: return 4;   1: return 1;   2, 3: return 13;
      4, 5, 6, 7: return 6;
      16: return 10; 17: return 8;  18: return 2;
      19, 20: return 13; 21: return 4; 22: return 6;
      23, 24: return 7;  25, 26, 27: return 4;
      default: return 13;
    endcase
  endfunction

  function automatic string freq(int i);
    int l = fline(i);
    if (l <= 2) return "R4";
    if (l <= 6) return "R5";
    if (l <= 8) return "R6";
    return "R7";
  endfunction

  function automatic int get_out(int i);
    case (i)
      0: return int'(core_id);        1: return int'(tail_en);
      2: return int'(seed_a);         3: return int'(seed_b);
      4: return int'(iter_init);      5: return int'(iter_max);
      6: return int'(trellis_states); 7: return int'(step_count);
      16: return int'(tail_base);     17: return int'(ext_scale);
      18: return int'(std_mode);      19: return int'(prev_step);
      20: return int'(block_len);     21: return int'(core_count);
      22: return int'(step_index);    23: return int'(win_len);
      24: return int'(last_win_len);  25: return int'(win_cnt);
      26: return int'(tail_win_id);   27: return int'(tail_win_cnt);
      default: return int'(step_vals[(i - 8) * 13 +: 13]);
    endcase
  endfunction

  function automatic int gen(int seed, int i);
    if (i == 23 || i == 24) return (seed * 7 + i) % 65;
    if (i == 25 || i == 27) return (seed * 5 + i) % 13;
    return (seed * 131 + i * 29 + 7) % (1 << fwid(i));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_load(input int seed, input int len, input bit inject);
    int  n;
    int  nv [NF];
    int  m [NF];
    bit  bad;
    int  cycles;
    int  reads;
    bit  addr_ok;
    bit  hold_ok;
    bit  setup_ok;
    bit  idle_ok;
    n = (len > 16) ? 16 : len;
    cycles = 0; reads = 0; addr_ok = 1; hold_ok = 1; idle_ok = 1;
    for (int i = 0; i < NF; i++) begin
      nv[i] = gen(seed, i);
      if (i == ov_idx) nv[i] = ov_val;
    end
    for (int l = 0; l < 16; l++) mem[l] = (l > 10) ? 26'h3FF_FFFF : 26'h0;
    for (int i = 0; i < NF; i++)
      mem[fline(i)] = mem[fline(i)] | (26'(nv[i]) << flsb(i));
    for (int i = 0; i < NF; i++) m[i] = (fline(i) < n) ? nv[i] : cur[i];
    bad = (m[23] > 64) || (m[24] > 64) || (m[25] > 12) || (m[27] > 12);

    @(negedge clk);
    start = 1'b1;
    cfg_len = 5'(len);
    @(negedge clk);
    start = 1'b0;
    setup_ok = busy && !cfg_rd_en;
    chk(setup_ok, "R2", "setup cycle busy without read", int'(cfg_rd_en), 0);
    while (busy && cycles < 100) begin
      cycles++;
      if (cfg_rd_en) begin
        if (int'(cfg_rd_addr) != reads) addr_ok = 0;
        reads++;
      end
      if (get_out(23) != cur[23] || get_out(20) != cur[20] ||
          get_out(0) != cur[0] || get_out(9) != cur[9] || ready) hold_ok = 0;
      if (inject && cycles == 3) start = 1'b1;
      if (inject && cycles == 4) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cycles == n + 2, inject ? "R11" : "R3", "busy cycles", cycles, n + 2);
    chk(reads == n, "R2", "read count", reads, n);
    chk(addr_ok, "R2", "consecutive addresses", int'(addr_ok), 1);
    chk(hold_ok, "R9", "outputs held during load", int'(hold_ok), 1);
    chk(ready == !bad, bad ? "R10" : "R3", "ready", int'(ready), int'(!bad));
    chk(cfg_err == bad, "R10", "cfg_err", int'(cfg_err), int'(bad));
    for (int i = 0; i < NF; i++) begin
      int e;
      e = bad ? cur[i] : m[i];
      if (bad)
        chk(get_out(i) == e, "R10", $sformatf("field %0d kept", i), get_out(i), e);
      else if (fline(i) >= n)
        chk(get_out(i) == e, "R8", $sformatf("field %0d unread", i), get_out(i), e);
      else
        chk(get_out(i) == e, freq(i), $sformatf("field %0d", i), get_out(i), e);
    end
    if (!bad) for (int i = 0; i < NF; i++) cur[i] = m[i];
    for (int k = 0; k < 6; k++) begin
      if (cfg_rd_en || busy) idle_ok = 0;
      @(negedge clk);
    end
    chk(idle_ok, inject ? "R11" : "R12", "no reads or restart after completion",
        int'(idle_ok), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nfail++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    bit r1_ok;
    for (int i = 0; i < NF; i++) cur[i] = 0;
    for (int l = 0; l < 16; l++) mem[l] = '0;
    repeat (3) @(negedge clk);
    r1_ok = !busy && !ready && !cfg_err && !cfg_rd_en;
    chk(r1_ok, "R1", "flags in reset", int'(r1_ok), 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    r1_ok = !busy && !ready && !cfg_err && !cfg_rd_en;
    chk(r1_ok, "R1", "flags after reset", int'(r1_ok), 1);
    for (int i = 0; i < NF; i++)
      chk(get_out(i) == 0, "R1", $sformatf("field %0d after reset", i), get_out(i), 0);

    // Full-layout loads, the second with a start pulse mid-load (R11)
    run_load(1, 11, 1'b0);
    run_load(2, 11, 1'b1);

    // Length sweep: every count 0..20, fresh pattern each (R3, R8)
    for (int len = 0; len <= 20; len++) run_load(10 + len, len, 1'b0);

    // Range limits (R10)
    ov_idx = 23; ov_val = 65; run_load(40, 11, 1'b0);
    ov_idx = 23; ov_val = 64; run_load(41, 11, 1'b0);
    ov_idx = 24; ov_val = 65; run_load(42, 11, 1'b0);
    ov_idx = 24; ov_val = 64; run_load(43, 11, 1'b0);
    ov_idx = 25; ov_val = 13; run_load(44, 11, 1'b0);
    ov_idx = 25; ov_val = 12; run_load(45, 11, 1'b0);
    ov_idx = 27; ov_val = 13; run_load(46, 11, 1'b0);
    ov_idx = 27; ov_val = 12; run_load(47, 11, 1'b0);
    ov_idx = -1;
    run_load(48, 11, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule